// File: doc/BRIEF.md
# Bus Setup/Hold Window Checker

This block watches a data bus and the reference clock that is meant to capture it. Both come in as bit streams sampled by one fast sample clock. The block itself runs on that fast clock. A rising sample of the reference stream marks an active capture edge. Around each such edge the block checks whether any data bit changed too close to it, on every bit of the bus at once.

A change shortly before the edge is a setup fault. A change shortly after it is a hold fault. The two windows are separate run-time values, counted in fast samples; a common setting makes the setup window twice the hold window.

For each checked sample the block reports which bits broke setup, which broke hold, and a bus-wide violation pulse. A trigger latches on the first violation after arming and records the sample index of that violation. A saturating counter totals the violating samples, so that rates can be derived from it. A pulse on the arm input clears the trigger and the counter, which starts a new capture.

Top module: `shv_checker`

## Requirements
- R1: While reset is high, and in the cycle after it, every output is zero.
- R2: An active edge is a sample with the reference at 1 whose previous sample was 0. A data transition is a bit that differs from its previous sample. The first sample after reset has no predecessor, so it is never an edge and holds no transition.
- R3: At an active edge at sample e, bit b gets a setup flag if its most recent transition at sample t satisfies 0 <= e - t < setup_n. A change in the edge sample itself therefore counts as setup. A setup_n of 0 disables setup checking.
- R4: A transition of bit b at sample t gets a hold flag if the most recent earlier edge e satisfies 1 <= t - e <= hold_n. Here hold_n is the value present at edge e. A hold_n of 0 disables hold checking.
- R5: A new edge inside an open hold window restarts the window from that edge. In the edge sample itself the older window still applies. Flags from both windows combine by OR, so one transition can set both flags of its bit.
- R6: Flags are kept per bit. Only the bits that changed are flagged. Outputs for a sample appear one cycle after that sample is taken.
- R7: viol_pulse is high for exactly the output cycles in which some setup or hold flag is set.
- R8: trig_latched rises with the first violating sample and stays high until arm. trig_fire is a one-cycle pulse when the trigger newly sets. arm clears the trigger, but a violation in the same sample as arm sets it again.
- R9: trig_stamp holds the index of the sample that set the trigger. The first sample after reset has index 0, and the index wraps at 2^TS_W.
- R10: viol_count adds one per violating sample and saturates at its maximum. arm clears it, and a violation in the arm sample leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Re-arm pulse: clears trigger and counter |
| setup_n | input | WIN_W | Setup window in fast samples |
| hold_n | input | WIN_W | Hold window in fast samples |
| ref_s | input | 1 | Sampled reference clock |
| data_s | input | W | Sampled data bus |
| setup_flag | output | W | Per-bit setup violation flags |
| hold_flag | output | W | Per-bit hold violation flags |
| viol_pulse | output | 1 | Any violation in this sample |
| trig_fire | output | 1 | One-cycle trigger pulse |
| trig_latched | output | 1 | Sticky trigger |
| trig_stamp | output | TS_W | Sample index of the triggering violation |
| viol_count | output | CNT_W | Saturating count of violating samples |

## Verification
The properties assume that reset is held high for at least one clock before use. They also assume that ref_s and data_s are already synchronous to the fast clock, so the block never sees metastable values. The bench drives every input just after the falling edge, so each sample is clean. It keeps the window values at or below the representable maximum, and it changes them only between bursts of random traffic. The random traffic toggles the reference at irregular intervals and flips sparse data bits, so windows overlap and edges crowd together without any timing that the block cannot see.

// File: rtl/shv_pkg.sv
package shv_pkg;

    // Default geometry shared by the checker and its bench
    localparam int unsigned SHV_BUS_W  = 8;
    localparam int unsigned SHV_WIN_W  = 6;
    localparam int unsigned SHV_CNT_W  = 16;
    localparam int unsigned SHV_TS_W   = 20;

    // Per-sample view of the incoming streams
    typedef struct packed {
        logic primed;     // a previous sample exists
        logic clk_rise;   // active reference edge in this sample
    } shv_front_t;

    // Saturating increment on a 32-bit carrier, clipped to lim
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
        return (v >= lim) ? lim : v + 32'd1;
    endfunction

endpackage

// File: rtl/shv_sample_front.sv
module shv_sample_front
    import shv_pkg::*;
#(
    parameter int unsigned W = SHV_BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_s,
    input  logic [W-1:0] data_s,
    output shv_front_t   front,
    output logic [W-1:0] trans
);
    logic         primed_q;
    logic         ref_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            ref_q    <= 1'b0;
            data_q   <= '0;
        end else begin
            primed_q <= 1'b1;
            ref_q    <= ref_s;
            data_q   <= data_s;
        end
    end

    always_comb begin
        front.primed   = primed_q;
        front.clk_rise = primed_q & ref_s & ~ref_q;
        trans          = primed_q ? (data_s ^ data_q) : '0;
    end
endmodule

// File: rtl/shv_setup_age.sv
module shv_setup_age
    import shv_pkg::*;
#(
    parameter int unsigned W     = SHV_BUS_W,
    parameter int unsigned WIN_W = SHV_WIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     trans,
    input  logic             clk_rise,
    input  logic [WIN_W-1:0] setup_n,
    output logic [W-1:0]     setup_hit
);
    localparam logic [WIN_W-1:0] AGE_MAX = {WIN_W{1'b1}};

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [WIN_W-1:0] age_q;   // samples since last change, counted from the next sample
        logic [WIN_W-1:0] age_now; // distance from last change to this sample

        always_comb begin
            age_now      = trans[b] ? '0 : age_q;
            setup_hit[b] = clk_rise & (age_now < setup_n);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                age_q <= AGE_MAX;
            end else if (trans[b]) begin
                age_q <= WIN_W'(1);
            end else begin
                age_q <= WIN_W'(sat_inc(32'(age_q), 32'(AGE_MAX)));
            end
        end
    end
endmodule

// File: rtl/shv_hold_win.sv
module shv_hold_win
    import shv_pkg::*;
#(
    parameter int unsigned W     = SHV_BUS_W,
    parameter int unsigned WIN_W = SHV_WIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     trans,
    input  logic             clk_rise,
    input  logic [WIN_W-1:0] hold_n,
    output logic [W-1:0]     hold_hit
);
    logic [WIN_W-1:0] left_q;   // samples still inside the open hold window
    logic             open_now;

    always_comb begin
        open_now = (left_q != '0);
        hold_hit = open_now ? trans : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (clk_rise) begin
            left_q <= hold_n;
        end else if (open_now) begin
            left_q <= left_q - WIN_W'(1);
        end
    end
endmodule

// File: rtl/shv_report.sv
module shv_report
    import shv_pkg::*;
#(
    parameter int unsigned W     = SHV_BUS_W,
    parameter int unsigned CNT_W = SHV_CNT_W,
    parameter int unsigned TS_W  = SHV_TS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [W-1:0]     setup_hit,
    input  logic [W-1:0]     hold_hit,
    output logic [W-1:0]     setup_flag,
    output logic [W-1:0]     hold_flag,
    output logic             viol_pulse,
    output logic             trig_fire,
    output logic             trig_latched,
    output logic [TS_W-1:0]  trig_stamp,
    output logic [CNT_W-1:0] viol_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TS_W-1:0]  sample_idx;
    logic             any_hit;
    logic             set_evt;
    logic             trig_keep;
    logic [CNT_W-1:0] cnt_base;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        any_hit   = |(setup_hit | hold_hit);
        trig_keep = trig_latched & ~arm;
        set_evt   = any_hit & ~trig_keep;
        cnt_base  = arm ? '0 : viol_count;
        cnt_nx    = cnt_base;
        if (any_hit && cnt_base != CNT_MAX) begin
            cnt_nx = cnt_base + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_flag   <= '0;
            hold_flag    <= '0;
            viol_pulse   <= 1'b0;
            trig_fire    <= 1'b0;
            trig_latched <= 1'b0;
            trig_stamp   <= '0;
            viol_count   <= '0;
            sample_idx   <= '0;
        end else begin
            setup_flag   <= setup_hit;
            hold_flag    <= hold_hit;
            viol_pulse   <= any_hit;
            trig_fire    <= set_evt;
            trig_latched <= any_hit | trig_keep;
            if (set_evt) begin
                trig_stamp <= sample_idx;
            end
            viol_count   <= cnt_nx;
            sample_idx   <= sample_idx + TS_W'(1);
        end
    end
endmodule

// File: rtl/shv_checker.sv
module shv_checker
    import shv_pkg::*;
#(
    parameter int unsigned W     = SHV_BUS_W,
    parameter int unsigned WIN_W = SHV_WIN_W,
    parameter int unsigned CNT_W = SHV_CNT_W,
    parameter int unsigned TS_W  = SHV_TS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [WIN_W-1:0] setup_n,
    input  logic [WIN_W-1:0] hold_n,
    input  logic             ref_s,
    input  logic [W-1:0]     data_s,
    output logic [W-1:0]     setup_flag,
    output logic [W-1:0]     hold_flag,
    output logic             viol_pulse,
    output logic             trig_fire,
    output logic             trig_latched,
    output logic [TS_W-1:0]  trig_stamp,
    output logic [CNT_W-1:0] viol_count
);
    shv_front_t   front;
    logic [W-1:0] trans;
    logic [W-1:0] setup_hit;
    logic [W-1:0] hold_hit;

    shv_sample_front #(.W(W)) u_front (
        .clk    (clk),
        .rst    (rst),
        .ref_s  (ref_s),
        .data_s (data_s),
        .front  (front),
        .trans  (trans)
    );

    shv_setup_age #(.W(W), .WIN_W(WIN_W)) u_setup (
        .clk       (clk),
        .rst       (rst),
        .trans     (trans),
        .clk_rise  (front.clk_rise),
        .setup_n   (setup_n),
        .setup_hit (setup_hit)
    );

    shv_hold_win #(.W(W), .WIN_W(WIN_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .trans    (trans),
        .clk_rise (front.clk_rise),
        .hold_n   (hold_n),
        .hold_hit (hold_hit)
    );

    shv_report #(.W(W), .CNT_W(CNT_W), .TS_W(TS_W)) u_report (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .setup_hit    (setup_hit),
        .hold_hit     (hold_hit),
        .setup_flag   (setup_flag),
        .hold_flag    (hold_flag),
        .viol_pulse   (viol_pulse),
        .trig_fire    (trig_fire),
        .trig_latched (trig_latched),
        .trig_stamp   (trig_stamp),
        .viol_count   (viol_count)
    );
endmodule

// File: rtl/shv_checker_sva.sv
module shv_checker_sva #(
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic             ref_s,
    input logic [W-1:0]     data_s,
    input logic [W-1:0]     setup_flag,
    input logic [W-1:0]     hold_flag,
    input logic             viol_pulse,
    input logic             trig_fire,
    input logic             trig_latched,
    input logic [CNT_W-1:0] viol_count
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (viol_count == '0 && !trig_latched && !viol_pulse && !trig_fire));

    // R8
    trig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_latched && !arm) |=> trig_latched);

    // R8
    fire_latch_chk: assert property (@(posedge clk) disable iff (rst)
        trig_fire |-> trig_latched);

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_count == CMAX && !arm) |=> (viol_count == CMAX));

    // R10
    count_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (viol_count >= $past(viol_count)));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> ({1'b0, viol_count} <= {1'b0, $past(viol_count)} + 1'b1));

    // R4
    hold_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
        (data_s == $past(data_s)) |=> (hold_flag == '0));

    // R3
    setup_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_flag != '0) |-> ($past(ref_s) && !$past(ref_s, 2)));
endmodule

bind shv_checker shv_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .arm          (arm),
    .ref_s        (ref_s),
    .data_s       (data_s),
    .setup_flag   (setup_flag),
    .hold_flag    (hold_flag),
    .viol_pulse   (viol_pulse),
    .trig_fire    (trig_fire),
    .trig_latched (trig_latched),
    .viol_count   (viol_count)
);

// File: tb/sim_shv_checker.sv
module sim_shv_checker;
    localparam int BW   = 8;
    localparam int WW   = 6;
    localparam int CW   = 8;
    localparam int TW   = 20;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic [WW-1:0] setup_n = '0;
    logic [WW-1:0] hold_n = '0;
    logic          ref_s = 1'b0;
    logic [BW-1:0] data_s = '0;
    logic [BW-1:0] setup_flag, hold_flag;
    logic          viol_pulse, trig_fire, trig_latched;
    logic [TW-1:0] trig_stamp;
    logic [CW-1:0] viol_count;

    always #2ns clk = ~clk;

    shv_checker #(.W(BW), .WIN_W(WW), .CNT_W(CW), .TS_W(TW)) u0 (
        .clk(clk), .rst(rst), .arm(arm), .setup_n(setup_n), .hold_n(hold_n),
        .ref_s(ref_s), .data_s(data_s), .setup_flag(setup_flag), .hold_flag(hold_flag),
        .viol_pulse(viol_pulse), .trig_fire(trig_fire), .trig_latched(trig_latched),
        .trig_stamp(trig_stamp), .viol_count(viol_count)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    bit            m_primed = 0;
    logic          m_prev_r = 0;
    logic [BW-1:0] m_prev_d = '0;
    int            m_t = 0;
    int            m_last_tr [BW];
    int            m_last_edge = -1000000;
    int            m_last_hv = 0;
    logic [BW-1:0] e_setup = '0, e_hold = '0;
    logic          e_pulse = 0, e_fire = 0, e_trig = 0;
    int            e_stamp = 0;
    int            e_cnt = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (sample %0d)", tag, act, exp, m_t - 1);
        end
    endtask

    task automatic model_sample(input logic r, input logic [BW-1:0] d);
        logic [BW-1:0] tr;
        logic          rise;
        logic          any;
        logic          set_evt;
        int            base;
        tr   = m_primed ? (d ^ m_prev_d) : '0;
        rise = m_primed && r && !m_prev_r;
        for (int b = 0; b < BW; b++) begin
            if (tr[b]) m_last_tr[b] = m_t;
            e_setup[b] = rise && ((m_t - m_last_tr[b]) < int'(setup_n));
            e_hold[b]  = tr[b] && ((m_t - m_last_edge) >= 1) && ((m_t - m_last_edge) <= m_last_hv);
        end
        if (rise) begin
            m_last_edge = m_t;
            m_last_hv   = int'(hold_n);
        end
        any     = |(e_setup | e_hold);
        set_evt = any && !(e_trig && !arm);
        e_trig  = any || (e_trig && !arm);
        e_fire  = set_evt;
        e_pulse = any;
        if (set_evt) e_stamp = m_t % (1 << TW);
        base = arm ? 0 : e_cnt;
        if (any && base < CMAX) base = base + 1;
        e_cnt = base;
        m_primed = 1;
        m_prev_r = r;
        m_prev_d = d;
        m_t++;
    endtask

    task automatic compare_all();
        chk("R3 setup_flag", 64'(setup_flag), 64'(e_setup));
        chk("R4 hold_flag", 64'(hold_flag), 64'(e_hold));
        chk("R7 viol_pulse", 64'(viol_pulse), 64'(e_pulse));
        chk("R8 trig_fire", 64'(trig_fire), 64'(e_fire));
        chk("R8 trig_latched", 64'(trig_latched), 64'(e_trig));
        chk("R9 trig_stamp", 64'(trig_stamp), 64'(e_stamp));
        chk("R10 viol_count", 64'(viol_count), 64'(e_cnt));
    endtask

    // called just after a falling edge: drive, sample, check
    task automatic step(input logic r, input logic [BW-1:0] d);
        ref_s  = r;
        data_s = d;
        @(posedge clk);
        model_sample(r, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n, input logic [BW-1:0] d);
        for (int i = 0; i < n; i++) step(1'b0, d);
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic          r;
        logic [BW-1:0] d;
        void'($urandom(32'd4242));
        for (int b = 0; b < BW; b++) m_last_tr[b] = -1000000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared by reset
        chk("R1 setup_flag", 64'(setup_flag), 64'd0);
        chk("R1 trig_latched", 64'(trig_latched), 64'd0);
        chk("R1 viol_count", 64'(viol_count), 64'd0);
        rst = 1'b0;
        setup_n = 6'd4;
        hold_n  = 6'd2;

        // R2: first sample is neither edge nor change
        step(1'b1, 8'hFF);
        chk("R2 first sample setup", 64'(setup_flag), 64'd0);
        chk("R2 first sample hold", 64'(hold_flag), 64'd0);
        idle(8, 8'hFF);

        // R3: change 3 samples before edge, window 4
        step(1'b0, 8'hFE);
        step(1'b0, 8'hFE);
        step(1'b0, 8'hFE);
        step(1'b1, 8'hFE);
        chk("R3 inside window", 64'(setup_flag), 64'h01);
        chk("R6 only changed bit", 64'(hold_flag), 64'h00);
        idle(8, 8'hFE);

        // R3 boundary: change 4 samples before edge
        step(1'b0, 8'hFC);
        idle(3, 8'hFC);
        step(1'b1, 8'hFC);
        chk("R3 boundary", 64'(setup_flag), 64'h00);
        // R4: change 2 samples after edge, window 2
        step(1'b0, 8'hFC);
        step(1'b0, 8'hF8);
        chk("R4 inside window", 64'(hold_flag), 64'h04);
        idle(8, 8'hF8);

        // R4 boundary: change 3 samples after edge
        step(1'b1, 8'hF8);
        step(1'b0, 8'hF8);
        step(1'b0, 8'hF8);
        step(1'b0, 8'hF0);
        chk("R4 boundary", 64'(hold_flag), 64'h00);
        idle(8, 8'hF0);

        // R3: change in the edge sample itself
        step(1'b1, 8'hE0);
        chk("R3 coincident", 64'(setup_flag), 64'h10);
        idle(8, 8'hE0);

        // R3: setup disabled
        setup_n = 6'd0;
        step(1'b0, 8'hC0);
        step(1'b1, 8'hC0);
        chk("R3 disabled", 64'(setup_flag), 64'h00);
        idle(8, 8'hC0);

        // R5: change at a second edge inside the first hold window
        setup_n = 6'd2;
        hold_n  = 6'd4;
        step(1'b1, 8'hC0);
        step(1'b0, 8'hC0);
        step(1'b1, 8'h80);
        chk("R5 setup part", 64'(setup_flag), 64'h40);
        chk("R5 hold part", 64'(hold_flag), 64'h40);
        idle(8, 8'h80);

        // R8/R9/R10: re-arm then trigger
        arm = 1'b1;
        step(1'b0, 8'h80);
        arm = 1'b0;
        chk("R8 cleared by arm", 64'(trig_latched), 64'd0);
        chk("R10 cleared by arm", 64'(viol_count), 64'd0);
        step(1'b1, 8'h80);
        step(1'b0, 8'h81);
        chk("R8 fire", 64'(trig_fire), 64'd1);
        chk("R9 stamp", 64'(trig_stamp), 64'(m_t - 1));
        step(1'b0, 8'h81);
        chk("R8 one shot", 64'(trig_fire), 64'd0);
        chk("R8 sticky", 64'(trig_latched), 64'd1);
        chk("R10 one", 64'(viol_count), 64'd1);

        // R10: saturation, every sample violates
        setup_n = 6'd63;
        hold_n  = 6'd63;
        arm = 1'b1;
        r = 1'b0;
        d = 8'h81;
        for (int i = 0; i < 300; i++) begin
            r = ~r;
            d = ~d;
            step(r, d);
            arm = 1'b0;
        end
        chk("R10 saturated", 64'(viol_count), 64'(CMAX));

        // random traffic
        r = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (i % 400 == 0) begin
                setup_n = WW'($urandom % 9);
                hold_n  = WW'($urandom % 9);
            end
            arm = (($urandom % 50) == 0);
            if (($urandom % 3) == 0) r = ~r;
            for (int b = 0; b < BW; b++)
                if (($urandom % 10) == 0) d[b] = ~d[b];
            step(r, d);
        end
        arm = 1'b0;

        summary();
        $finish;
    end
endmodule